// File: doc/BRIEF.md
# Interleaved Burst Address Generator

This block sits beside a synchronous cache data array. It produces the address for each beat of a four-beat line burst. A burst begins when either of two active-low start strobes is low at a rising clock edge. One strobe belongs to the processor and the other to the cache controller. When a burst begins, the block captures the external address as the burst base. From then on the two least significant address bits are replaced by the base's low bits XOR a beat counter. This gives the interleaved beat order that processors use to fill a cache line.

After the start beat, an active-low advance strobe steps the beat counter by one, modulo four. When the advance strobe is high, the counter holds, and the current address is repeated as a wait state. The upper address bits keep their loaded value for the whole burst. After four advances the address returns to the base. The processor strobe has priority, so a processor start abandons any burst already in progress whatever the controller strobe does. All inputs are sampled on the rising clock edge. An asynchronous active-low reset clears the block.

Top module: `burst_addr_gen`

## Requirements
- R1: When either start strobe is low at a rising edge, `burst_addr` equals the sampled `ext_addr` after that edge and `beat_idx` is 0.
- R2: A low processor strobe starts a new burst whatever the state of the controller strobe, and it discards the current beat position.
- R3: In a cycle where a start strobe is low, the advance strobe has no effect: `beat_idx` is 0 after the edge.
- R4: With both start strobes high and the advance strobe low, `beat_idx` increments modulo 4 and `burst_addr[1:0]` becomes base[1:0] XOR `beat_idx`.
- R5: With both start strobes high and the advance strobe high, `burst_addr` and `beat_idx` hold their values.
- R6: Address bits above bit 1 change only at a start.
- R7: The fourth advance after a start returns `burst_addr` to the loaded base and `beat_idx` to 0.
- R8: The low-bit order is interleaved: a base of 1 gives 1,0,3,2 and a base of 2 gives 2,3,0,1.
- R9: An asynchronous low on `rst_n` clears `burst_addr` and `beat_idx` to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_start_n | input | 1 | Processor start strobe, active low, has priority |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance strobe, active low |
| ext_addr | input | ADDR_W | External address sampled at a start |
| burst_addr | output | ADDR_W | Current beat address |
| beat_idx | output | CNT_W | Beats advanced since the start, modulo 4 |

## Verification
The assertions check the following on every clock:
- the load on a start, including the processor priority and the fact that the advance strobe is ignored in a start cycle;
- the single counter step on an advance;
- the hold on a wait cycle;
- the stability of the upper address bits;
- the return to the base on the wrap.

Only the bench scenarios can show the full interleaved sequences for particular bases and a burst abandoned in the middle. The same holds for the asynchronous reset, which clears the outputs between clock edges. The bench checks these against addresses it computes itself, both under random mixes of strobes and in directed sequences.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } start_src_e;
endpackage

// File: rtl/burst_start_decode.sv
module burst_start_decode
  import burst_pkg::*;
(
  input  logic       proc_start_n,
  input  logic       ctrl_start_n,
  output logic       load_evt,
  output start_src_e load_src
);
  // The processor strobe is tested first, so it wins when both are low.
  always_comb begin
    if (!proc_start_n)      load_src = SRC_PROC;
    else if (!ctrl_start_n) load_src = SRC_CTRL;
    else                    load_src = SRC_NONE;
  end

  assign load_evt = (load_src != SRC_NONE);
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             adv_evt,
  output logic [CNT_W-1:0] beat_q
);
  function automatic logic [CNT_W-1:0] step_beat(input logic [CNT_W-1:0] b);
    return b + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (adv_evt)  beat_q <= step_beat(beat_q);
  end

  AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> beat_q == '0); // R3

  AST_ADV_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_evt) |=> beat_q == CNT_W'($past(beat_q) + 1'b1)); // R4

  AST_WAIT_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv_evt) |=> $stable(beat_q)); // R5
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [CNT_W-1:0]  beat,
  output logic [CNT_W-1:0]  base_lo,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_q;

  function automatic logic [CNT_W-1:0] interleave(input logic [CNT_W-1:0] lo,
                                                  input logic [CNT_W-1:0] b);
    return lo ^ b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (load_evt) base_q <= ext_addr;
  end

  assign base_lo    = base_q[CNT_W-1:0];
  assign burst_addr = {base_q[ADDR_W-1:CNT_W], interleave(base_q[CNT_W-1:0], beat)};

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> burst_addr[ADDR_W-1:CNT_W] == $past(ext_addr[ADDR_W-1:CNT_W])); // R1

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> burst_addr[ADDR_W-1:CNT_W] == $past(burst_addr[ADDR_W-1:CNT_W])); // R6

  initial assert (HI_W > 0); // R6
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  beat_idx
);
  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic             load_evt;
  logic             adv_evt;
  start_src_e       load_src;
  logic [CNT_W-1:0] beat;
  logic [CNT_W-1:0] base_lo;

  assign adv_evt = !adv_n;

  burst_start_decode u_dec (
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .load_evt     (load_evt),
    .load_src     (load_src)
  );

  burst_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .beat_q   (beat)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_areg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt   (load_evt),
    .ext_addr   (ext_addr),
    .beat       (beat),
    .base_lo    (base_lo),
    .burst_addr (burst_addr)
  );

  assign beat_idx = beat;

  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_start_n |-> (load_evt && load_src == SRC_PROC)); // R2

  AST_START_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n || !ctrl_start_n) |=> (burst_addr == $past(ext_addr) && beat_idx == '0)); // R1

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start_n && ctrl_start_n && !adv_n && beat_idx == LAST_BEAT)
      |=> (burst_addr[CNT_W-1:0] == base_lo && beat_idx == '0)); // R7
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int  ADDR_W = 16;
  localparam int  CNT_W  = 2;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              proc_start_n = 1'b1;
  logic              ctrl_start_n = 1'b1;
  logic              adv_n = 1'b1;
  logic [ADDR_W-1:0] ext_addr = '0;
  logic [ADDR_W-1:0] burst_addr;
  logic [CNT_W-1:0]  beat_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] m_base = '0;
  int                m_beat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .proc_start_n(proc_start_n),
    .ctrl_start_n(ctrl_start_n), .adv_n(adv_n), .ext_addr(ext_addr),
    .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  function automatic logic [ADDR_W-1:0] want_addr(input logic [ADDR_W-1:0] base, input int b);
    logic [1:0] lo;
    lo = base[1:0];
    case (b % 4)
      1: lo = {lo[1], ~lo[0]};
      2: lo = {~lo[1], lo[0]};
      3: lo = ~lo;
      default: ;
    endcase
    return {base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [ADDR_W-1:0] ea, input int eb);
    checks++;
    if (burst_addr !== ea || beat_idx !== CNT_W'(eb)) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, burst_addr, beat_idx, ea, eb);
    end
  endtask

  // Called at a falling edge: drive, model, wait one edge, compare.
  task automatic step(input bit p, input bit c, input bit a,
                      input logic [ADDR_W-1:0] addr, input string tag);
    proc_start_n = p; ctrl_start_n = c; adv_n = a; ext_addr = addr;
    if (!p || !c) begin m_base = addr; m_beat = 0; end
    else if (!a)  m_beat = (m_beat + 1) % 4;
    @(posedge clk); @(negedge clk);
    check(tag, want_addr(m_base, m_beat), m_beat);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2);
    check("R9 reset", '0, 0);
    @(negedge clk); rst_n = 1'b1;

    // R8 interleaved order from base low bits 1; R2 processor start
    step(0, 1, 1, 16'hA5C1, "R2 proc start");
    step(1, 1, 0, 16'h0000, "R8 beat1");
    step(1, 1, 0, 16'h0000, "R8 beat2");
    step(1, 1, 1, 16'h0000, "R5 wait");
    step(1, 1, 0, 16'h0000, "R8 beat3");
    step(1, 1, 0, 16'h0000, "R7 wrap");
    // R8 base low bits 2 via controller; R1
    step(1, 0, 1, 16'h3F02, "R1 ctrl start");
    step(1, 1, 0, 16'hFFFF, "R8 b2 beat1");
    step(1, 1, 0, 16'hFFFF, "R8 b2 beat2");
    // R2 both strobes low mid-burst abandons it; R3 advance ignored
    step(0, 0, 0, 16'h1233, "R2 both low");
    step(1, 1, 0, 16'h0000, "R4 step");
    step(0, 1, 0, 16'h7777, "R3 adv in start");
    step(1, 1, 1, 16'hABCD, "R6 upper held");

    for (int i = 0; i < 400; i++) begin
      bit p, c, a;
      string t;
      p = ($urandom % 6) != 0;
      c = ($urandom % 5) != 0;
      a = ($urandom % 3) == 0;
      t = (!p || !c) ? "R1 rand" : (!a ? "R4 rand" : "R5 rand");
      step(p, c, a, ADDR_W'($urandom), t);
    end

    // R9 async clear mid-burst, between edges
    step(1, 1, 0, 16'h0000, "R4 pre-reset");
    #(CLK_PERIOD/4); rst_n = 1'b0; #1;
    check("R9 async", '0, 0);
    m_base = '0; m_beat = 0;
    @(negedge clk); rst_n = 1'b1;
    step(1, 1, 0, 16'h0000, "R4 after reset");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule